// File: doc/BRIEF.md
# Flash Command Register Interface

This block sits between an asynchronous byte-wide flash bus and the on-chip erase/program sequencer. It samples the active-low chip-select, output-enable and write-enable strobes, the address and data buses and a "programming voltage present" level through a two-flop synchroniser. From these it qualifies bus write cycles, rejects short strobe pulses, and turns one- and two-write command sequences into program and chip-erase requests. It also chooses what a bus read returns: array data, an identifier byte, or the sequencer's polling status.

A write cycle is the interval in which chip-select and write-enable are both low while output-enable is high. The address is taken when that interval opens, which is when the later of the two strobes falls. The data is taken when it closes, which is when the earlier of the two strobes rises. The command state machine has four states. ST_READ is the array read mode. ST_ID is the identifier mode. ST_PGM_SETUP waits for the program address and data. ST_ERS_SETUP waits for the erase confirmation.

The state machine takes these transitions:
- From ST_READ or ST_ID, a write of 00h or FFh goes to ST_READ.
- From ST_READ or ST_ID, a write of 80h or 90h goes to ST_ID.
- From ST_READ or ST_ID, a write of 30h goes to ST_ERS_SETUP.
- From ST_READ or ST_ID, a write of 10h or 50h goes to ST_PGM_SETUP.
- From ST_READ or ST_ID, any other code goes to ST_READ.
- From ST_PGM_SETUP, a write of FFh cancels and goes to ST_READ. Any other write issues a program request and goes to ST_READ.
- From ST_ERS_SETUP, a write of 30h issues an erase request. Any write returns the machine to ST_READ.
- Whenever the voltage-present input is low, the machine is forced to ST_READ.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the block is in read-array mode, dout_oe is low and neither request is raised. A read of any address returns array_rdata.
- R2: While vpp_ok is low, writes have no effect and the mode is forced to read-array.
- R3: A write is accepted only while ce_n=0, we_n=0 and oe_n=1. With oe_n low, or with only one of ce_n/we_n low, nothing is written.
- R4: A write whose qualified low time is shorter than MIN_LOW_CYC clock cycles (default 3, i.e. 15 ns at 200 MHz) is ignored. A write of 4 cycles is accepted.
- R5: The address of a write is sampled when the later of ce_n/we_n falls. The data is sampled when the earlier of the two rises.
- R6: Writing 00h or FFh selects read-array mode, in which reads return array_rdata. The mode persists until another command is accepted.
- R7: Writing 80h or 90h selects identifier mode. Reading address 0 returns 01h and address 1 returns 29h. Bit 7 of each is the odd-parity bit over bits 6:0. Any other address returns 00h.
- R8: A write of 30h followed by a write of 30h raises erase_req for one cycle. If 30h is followed by any other value, no erase is requested and the block returns to read-array mode.
- R9: A write of 10h or 50h followed by a write of any value other than FFh raises pgm_req for one cycle. pgm_addr and pgm_data then carry the second write's address and data. pgm_req and erase_req are never high together.
- R10: Two consecutive writes of 00h/FFh return the block to read-array mode from any mode. FFh as the second write after a program set-up cancels the program.
- R11: If ce_n and we_n are low with oe_n high when reset is released, the rising strobe that ends that cycle is not taken as a command.
- R12: While seq_busy is high, writes are ignored and reads return seq_status.
- R13: dout_oe is high exactly while ce_n and oe_n are both low, delayed by the synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Bus chip select, active low, asynchronous |
| oe_n | input | 1 | Bus output enable, active low, asynchronous |
| we_n | input | 1 | Bus write enable, active low, asynchronous |
| addr | input | AW | Bus address |
| din | input | 8 | Bus write data |
| vpp_ok | input | 1 | High while programming voltage is present |
| seq_busy | input | 1 | Sequencer is running a program or erase |
| seq_status | input | 8 | Polling status returned during busy reads |
| array_rdata | input | 8 | Array data for the current address |
| dout | output | 8 | Read data toward the pad drivers |
| dout_oe | output | 1 | Output enable for the pad drivers |
| pgm_req | output | 1 | One-cycle program request |
| pgm_addr | output | AW | Program target address |
| pgm_data | output | 8 | Program data |
| erase_req | output | 1 | One-cycle chip-erase request |

## Verification
Strobe edges pass two synchroniser flops before the write qualifier sees them. A command therefore appears as pgm_req/erase_req or as a changed mode on the fourth clock edge after the releasing strobe edge, and the bench waits six cycles before it looks. dout is registered one edge after the address and mode settle, while dout_oe follows ce_n/oe_n by three edges. Read checks sample five cycles after the strobes are applied. All inputs change and all outputs are sampled on the falling clock edge, so no check lands on an edge where a value is changing.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        ST_READ      = 2'd0,
        ST_ID        = 2'd1,
        ST_PGM_SETUP = 2'd2,
        ST_ERS_SETUP = 2'd3
    } cmd_state_e;

    localparam logic [7:0] CODE_RD_A  = 8'h00;
    localparam logic [7:0] CODE_RD_B  = 8'hFF;
    localparam logic [7:0] CODE_ID_A  = 8'h80;
    localparam logic [7:0] CODE_ID_B  = 8'h90;
    localparam logic [7:0] CODE_ERS   = 8'h30;
    localparam logic [7:0] CODE_PGM_A = 8'h10;
    localparam logic [7:0] CODE_PGM_B = 8'h50;

    // Identifier byte: bit 7 completes odd parity over bits 6:0.
    function automatic logic [7:0] id_byte(input logic [6:0] low);
        return {~^low, low};
    endfunction

    // Next mode chosen by a first-cycle command code.
    function automatic cmd_state_e first_cycle_mode(input logic [7:0] code);
        cmd_state_e m;
        case (code)
            CODE_ID_A, CODE_ID_B:   m = ST_ID;
            CODE_ERS:               m = ST_ERS_SETUP;
            CODE_PGM_A, CODE_PGM_B: m = ST_PGM_SETUP;
            default:                m = ST_READ;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/flash_strobe_sync.sv
module flash_strobe_sync #(
    parameter int           W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                sync_q <= RST_VAL[i];
            end else begin
                meta_q <= d_async[i];
                sync_q <= meta_q;
            end
        end
        assign q[i] = sync_q;
    end
endmodule

// File: rtl/flash_write_qual.sv
module flash_write_qual #(
    parameter int AW          = 18,
    parameter int MIN_LOW_CYC = 3,
    localparam int CNT_W      = $clog2(MIN_LOW_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_s,
    input  logic          oe_s,
    input  logic          we_s,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);
    logic             act;
    logic             act_q;
    logic             armed_q;
    logic [CNT_W-1:0] low_cnt_q;
    logic             opening;
    logic             closing;
    logic             long_enough;

    assign act         = ~ce_s & ~we_s & oe_s;
    assign opening     = act & ~act_q;
    assign closing     = ~act & act_q;
    assign long_enough = (low_cnt_q >= CNT_W'(MIN_LOW_CYC));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q     <= 1'b1;
            armed_q   <= 1'b0;
            low_cnt_q <= '0;
            wr_valid  <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            act_q    <= act;
            wr_valid <= 1'b0;
            if (!act) begin
                armed_q <= 1'b1;
            end
            if (opening) begin
                wr_addr   <= addr;
                low_cnt_q <= CNT_W'(1);
            end else if (act && !long_enough) begin
                low_cnt_q <= low_cnt_q + 1'b1;
            end
            // Closing by a strobe rise (not by OE dropping), long, and armed.
            if (closing && oe_s && long_enough && armed_q) begin
                wr_valid <= 1'b1;
                wr_data  <= din;
            end
        end
    end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vpp_s,
    input  logic          seq_busy,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    output cmd_state_e    state,
    output logic          pgm_req,
    output logic [AW-1:0] pgm_addr,
    output logic [7:0]    pgm_data,
    output logic          erase_req
);
    cmd_state_e nxt_state;
    logic       do_pgm;
    logic       do_ers;
    logic       take;

    assign take = wr_valid & ~seq_busy;

    always_comb begin
        nxt_state = state;
        do_pgm    = 1'b0;
        do_ers    = 1'b0;
        if (!vpp_s) begin
            nxt_state = ST_READ;
        end else if (take) begin
            unique case (state)
                ST_READ, ST_ID: begin
                    nxt_state = first_cycle_mode(wr_data);
                end
                ST_PGM_SETUP: begin
                    do_pgm    = (wr_data != CODE_RD_B);
                    nxt_state = ST_READ;
                end
                ST_ERS_SETUP: begin
                    do_ers    = (wr_data == CODE_ERS);
                    nxt_state = ST_READ;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_READ;
        end else begin
            state <= nxt_state;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pgm_req   <= 1'b0;
            erase_req <= 1'b0;
            pgm_addr  <= '0;
            pgm_data  <= '0;
        end else begin
            pgm_req   <= do_pgm;
            erase_req <= do_ers;
            if (do_pgm) begin
                pgm_addr <= wr_addr;
                pgm_data <= wr_data;
            end
        end
    end
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
    import flash_cmd_pkg::*;
#(
    parameter int         AW          = 18,
    parameter int         MIN_LOW_CYC = 3,
    parameter logic [6:0] MFR_CODE    = 7'h01,
    parameter logic [6:0] DEV_CODE    = 7'h29
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    input  logic          vpp_ok,
    input  logic          seq_busy,
    input  logic [7:0]    seq_status,
    input  logic [7:0]    array_rdata,
    output logic [7:0]    dout,
    output logic          dout_oe,
    output logic          pgm_req,
    output logic [AW-1:0] pgm_addr,
    output logic [7:0]    pgm_data,
    output logic          erase_req
);
    // Bit order: 0 ce, 1 we, 2 oe, 3 vpp. Reset looks like an open write
    // cycle so that one already in progress at power-up is never armed.
    localparam logic [3:0] SYNC_RST = 4'b0100;

    logic [3:0]    sync_q;
    logic          ce_s, we_s, oe_s, vpp_s;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    cmd_state_e    cur_state;
    logic [7:0]    rd_mux;

    flash_strobe_sync #(.W(4), .RST_VAL(SYNC_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({vpp_ok, oe_n, we_n, ce_n}),
        .q       (sync_q)
    );

    assign ce_s  = sync_q[0];
    assign we_s  = sync_q[1];
    assign oe_s  = sync_q[2];
    assign vpp_s = sync_q[3];

    flash_write_qual #(.AW(AW), .MIN_LOW_CYC(MIN_LOW_CYC)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_s     (ce_s),
        .oe_s     (oe_s),
        .we_s     (we_s),
        .addr     (addr),
        .din      (din),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    flash_cmd_fsm #(.AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .vpp_s     (vpp_s),
        .seq_busy  (seq_busy),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .state     (cur_state),
        .pgm_req   (pgm_req),
        .pgm_addr  (pgm_addr),
        .pgm_data  (pgm_data),
        .erase_req (erase_req)
    );

    always_comb begin
        if (seq_busy) begin
            rd_mux = seq_status;
        end else if (cur_state == ST_ID) begin
            if (addr == '0) begin
                rd_mux = id_byte(MFR_CODE);
            end else if (addr == AW'(1)) begin
                rd_mux = id_byte(DEV_CODE);
            end else begin
                rd_mux = 8'h00;
            end
        end else begin
            rd_mux = array_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_oe <= 1'b0;
        end else begin
            dout    <= rd_mux;
            dout_oe <= ~ce_s & ~oe_s;
        end
    end
endmodule

// File: rtl/flash_cmd_if_chk.sv
module flash_cmd_if_chk
    import flash_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       vpp_s,
    input logic       seq_busy,
    input logic       wr_valid,
    input cmd_state_e state,
    input logic       pgm_req,
    input logic       erase_req
);
    AST_VPP_FORCES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !vpp_s |=> state == ST_READ);                                   // R2
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pgm_req, erase_req}));                                // R9
    AST_PGM_FROM_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_req |-> $past(state) == ST_PGM_SETUP);                      // R9
    AST_ERS_FROM_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> $past(state) == ST_ERS_SETUP);                    // R8
    AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |=> !pgm_req && !erase_req);                           // R12
    AST_MODE_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_valid && vpp_s) |=> $stable(state));                       // R6
endmodule

bind flash_cmd_if flash_cmd_if_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .vpp_s     (vpp_s),
    .seq_busy  (seq_busy),
    .wr_valid  (wr_valid),
    .state     (cur_state),
    .pgm_req   (pgm_req),
    .erase_req (erase_req)
);

// File: tb/flash_cmd_if_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_if_tb_top;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic          vpp_ok = 1'b1;
    logic          seq_busy = 1'b0;
    logic [7:0]    seq_status = 8'h00;
    logic [7:0]    array_rdata;
    logic [7:0]    dout;
    logic          dout_oe;
    logic          pgm_req;
    logic [AW-1:0] pgm_addr;
    logic [7:0]    pgm_data;
    logic          erase_req;

    int vectors = 0;
    int fails = 0;
    int pgm_cnt = 0;
    int ers_cnt = 0;
    logic [AW-1:0] last_pa = '0;
    logic [7:0]    last_pd = '0;

    always #2.5 clk = ~clk;

    assign array_rdata = addr[7:0] ^ 8'h5A;

    flash_cmd_if #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .vpp_ok(vpp_ok), .seq_busy(seq_busy),
        .seq_status(seq_status), .array_rdata(array_rdata), .dout(dout),
        .dout_oe(dout_oe), .pgm_req(pgm_req), .pgm_addr(pgm_addr),
        .pgm_data(pgm_data), .erase_req(erase_req)
    );

    always @(posedge clk) begin
        if (pgm_req) begin
            pgm_cnt <= pgm_cnt + 1;
            last_pa <= pgm_addr;
            last_pd <= pgm_data;
        end
        if (erase_req) ers_cnt <= ers_cnt + 1;
    end

    function automatic logic [7:0] exp_id(input logic [6:0] low);
        return {~^low, low};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write_ex(input logic [AW-1:0] a, input logic [7:0] d,
                                input int low, input logic oe_val);
        @(negedge clk);
        addr = a; din = d; oe_n = oe_val; ce_n = 1'b0; we_n = 1'b0;
        cyc(low);
        ce_n = 1'b1; we_n = 1'b1;
        cyc(4);
        oe_n = 1'b1;
        cyc(2);
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        bus_write_ex(a, d, 4, 1'b1);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        cyc(5);
        d = dout; oe = dout_oe;
        ce_n = 1'b1; oe_n = 1'b1;
        cyc(4);
    endtask

    task automatic expect_read(input string req, input logic [AW-1:0] a, input logic [7:0] e);
        logic [7:0] d; logic oe;
        bus_read(a, d, oe);
        chk(req, {24'd0, d}, {24'd0, e});
    endtask

    task automatic t_reset();
        chk("R1 dout_oe after reset", {31'd0, dout_oe}, 32'd0);
        chk("R1 no program after reset", pgm_cnt, 0);
        chk("R1 no erase after reset", ers_cnt, 0);
        expect_read("R1 read mode after reset", 18'h00003, 8'h03 ^ 8'h5A);
    endtask

    task automatic t_oe();
        logic [7:0] d; logic oe;
        bus_read(18'h00010, d, oe);
        chk("R13 dout_oe while selected", {31'd0, oe}, 32'd1);
        chk("R13 dout_oe after release", {31'd0, dout_oe}, 32'd0);
    endtask

    task automatic t_id_and_read();
        bus_write(18'h00000, 8'h90);
        expect_read("R7 manufacturer byte", 18'h00000, exp_id(7'h01));
        expect_read("R7 device byte", 18'h00001, exp_id(7'h29));
        expect_read("R7 other address", 18'h00002, 8'h00);
        bus_write(18'h00000, 8'h80);
        expect_read("R7 80h also identifier", 18'h00001, exp_id(7'h29));
        bus_write(18'h00000, 8'hFF);
        expect_read("R6 FFh returns to array", 18'h00001, 8'h01 ^ 8'h5A);
        expect_read("R6 mode persists", 18'h00022, 8'h22 ^ 8'h5A);
        bus_write(18'h00000, 8'h90);
        bus_write(18'h00000, 8'h00);
        expect_read("R6 00h returns to array", 18'h00000, 8'h5A);
    endtask

    task automatic t_vpp();
        vpp_ok = 1'b0;
        cyc(4);
        bus_write(18'h00000, 8'h90);
        expect_read("R2 write without vpp ignored", 18'h00000, 8'h5A);
        bus_write(18'h00000, 8'h50);
        bus_write(18'h00100, 8'h11);
        chk("R2 no program without vpp", pgm_cnt, 0);
        vpp_ok = 1'b1;
        cyc(4);
    endtask

    task automatic t_inhibit();
        bus_write_ex(18'h00000, 8'h90, 4, 1'b0);
        expect_read("R3 write with oe low ignored", 18'h00000, 8'h5A);
        @(negedge clk);
        din = 8'h90; we_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
        cyc(5);
        we_n = 1'b1;
        cyc(6);
        expect_read("R3 write with ce high ignored", 18'h00000, 8'h5A);
    endtask

    task automatic t_glitch();
        bus_write_ex(18'h00000, 8'h90, 2, 1'b1);
        expect_read("R4 short strobe ignored", 18'h00000, 8'h5A);
        bus_write_ex(18'h00000, 8'h90, 4, 1'b1);
        expect_read("R4 long strobe accepted", 18'h00000, exp_id(7'h01));
        bus_write(18'h00000, 8'hFF);
    endtask

    task automatic t_erase();
        int e0;
        e0 = ers_cnt;
        bus_write(18'h00000, 8'h30);
        bus_write(18'h00000, 8'h30);
        chk("R8 erase requested", ers_cnt - e0, 1);
        e0 = ers_cnt;
        bus_write(18'h00000, 8'h30);
        bus_write(18'h00000, 8'h40);
        chk("R8 bad confirm no erase", ers_cnt - e0, 0);
        expect_read("R8 bad confirm back to read", 18'h00005, 8'h05 ^ 8'h5A);
    endtask

    task automatic t_program();
        int p0;
        p0 = pgm_cnt;
        bus_write(18'h00000, 8'h50);
        bus_write(18'h21234, 8'hA7);
        chk("R9 program requested", pgm_cnt - p0, 1);
        chk("R9 program address", {14'd0, last_pa}, 32'h21234);
        chk("R9 program data", {24'd0, last_pd}, 32'hA7);
        bus_write(18'h00000, 8'h10);
        bus_write(18'h00055, 8'h00);
        chk("R9 10h program requested", pgm_cnt - p0, 2);
        chk("R9 program data zero", {24'd0, last_pd}, 32'h00);
    endtask

    task automatic t_skew();
        bus_write(18'h00000, 8'h10);
        @(negedge clk);
        addr = 18'h00AAA; din = 8'h3C; oe_n = 1'b1; we_n = 1'b0;
        cyc(4);
        addr = 18'h00BBB;
        cyc(4);
        ce_n = 1'b0;
        cyc(5);
        we_n = 1'b1;
        cyc(5);
        din = 8'hC3;
        cyc(2);
        ce_n = 1'b1;
        cyc(6);
        chk("R5 address at later fall", {14'd0, last_pa}, 32'h00BBB);
        chk("R5 data at earlier rise", {24'd0, last_pd}, 32'h3C);
    endtask

    task automatic t_reset_cmd();
        int p0;
        bus_write(18'h00000, 8'h90);
        bus_write(18'h00000, 8'hFF);
        bus_write(18'h00000, 8'hFF);
        expect_read("R10 reset from identifier", 18'h00000, 8'h5A);
        p0 = pgm_cnt;
        bus_write(18'h00000, 8'h50);
        bus_write(18'h00000, 8'hFF);
        chk("R10 FFh cancels program", pgm_cnt - p0, 0);
        bus_write(18'h00000, 8'hFF);
        expect_read("R10 read after cancel", 18'h00001, 8'h01 ^ 8'h5A);
    endtask

    task automatic t_busy();
        int e0;
        seq_busy = 1'b1; seq_status = 8'h80;
        expect_read("R12 status while busy", 18'h00000, 8'h80);
        e0 = ers_cnt;
        bus_write(18'h00000, 8'h30);
        bus_write(18'h00000, 8'h30);
        chk("R12 writes ignored while busy", ers_cnt - e0, 0);
        seq_busy = 1'b0;
        expect_read("R12 mode unchanged after busy", 18'h00000, 8'h5A);
    endtask

    task automatic t_powerup();
        @(negedge clk);
        rst_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; din = 8'h90; addr = '0;
        cyc(4);
        rst_n = 1'b1;
        cyc(6);
        we_n = 1'b1;
        cyc(6);
        ce_n = 1'b1;
        cyc(4);
        expect_read("R11 power-up strobe not a command", 18'h00000, 8'h5A);
        bus_write(18'h00000, 8'h90);
        expect_read("R11 later write accepted", 18'h00000, exp_id(7'h01));
        bus_write(18'h00000, 8'hFF);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_oe();
        t_id_and_read();
        t_vpp();
        t_inhibit();
        t_glitch();
        t_erase();
        t_program();
        t_skew();
        t_reset_cmd();
        t_busy();
        t_powerup();
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end
endmodule